// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block converts a 32-bit virtual address into a physical address by walking an in-memory translation table in hardware. A walk starts when a requester presents a virtual address on a valid/ready handshake. The first-level table sits at the base given on a table-base input. The walker reads one 32-bit first-level descriptor over a single-beat memory read port. For table pointers it then reads one second-level descriptor. When the walk ends it reports the physical address, the mapping size, the cacheable/bufferable pair, the domain and the access-permission field, or it raises a translation fault.

Only one walk is in flight at a time. Busy stays high from the cycle after acceptance until the cycle that carries the done pulse. Second-level tables come in two forms. A coarse table is indexed by virtual address bits [19:12]; a fine table is indexed by bits [19:10]. The parameter `TINY_EN` controls whether fine tables are reachable at all.

Top module: `tt_walker`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `busy`, `done`, `fault` and `mem_req` are 0 and `req_ready` is 1.
- R2: On acceptance, the first read is issued with `mem_req` high for exactly one cycle, one cycle after acceptance. Its address is {table_base[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor with bits [1:0]=2 is a section. The walk gives pa = {desc[31:20], va[19:0]}, page type 0, cb = desc[3:2], ap = {6'b0, desc[11:10]} and domain = desc[8:5], with no second read.
- R4: A first-level descriptor with bits [1:0]=1 points to a coarse table. The second read is at {desc[31:10], va[19:12], 2'b00}, and the domain is taken from desc[8:5].
- R5: A first-level descriptor with bits [1:0]=3 and `TINY_EN`=1 points to a fine table. The second read is at {desc[31:12], va[19:10], 2'b00}, and the domain is taken from desc[8:5].
- R6: A second-level descriptor with bits [1:0]=1 is a large page. The walk gives pa = {desc[31:16], va[15:0]}, page type 1, ap = desc[11:4] and cb = desc[3:2].
- R7: A second-level descriptor with bits [1:0]=2 is a small page. The walk gives pa = {desc[31:12], va[11:0]}, page type 2, ap = desc[11:4] and cb = desc[3:2].
- R8: A second-level descriptor with bits [1:0]=3 is a tiny page. The walk gives pa = {desc[31:10], va[9:0]}, page type 3, ap = {6'b0, desc[5:4]} and cb = desc[3:2].
- R9: A descriptor of type 0 at either level ends the walk with `fault` high. In that case pa, page type, cb, ap and domain are all 0, and no further read is issued.
- R10: With `TINY_EN`=0, a first-level descriptor of type 3 ends the walk with a fault, after only the first read.
- R11: `done` is a single-cycle pulse and `fault` is high only together with it. `done` occurs 2+L cycles after acceptance for one-read walks and 3+2L cycles after acceptance for two-read walks, where L is the read latency. `busy` stays high and `req_ready` stays low from the cycle after acceptance until `done`. A `req_valid` held high during that time starts no extra read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| table_base | input | 32 | Translation table base, bits [31:14] used |
| mem_req | output | 1 | Descriptor read strobe, one cycle |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid, one cycle |
| fault | output | 1 | Translation fault, with done |
| pa | output | 32 | Physical address |
| page_type | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| cb | output | 2 | Cacheable/bufferable bits |
| domain | output | 4 | Domain from first-level descriptor |
| ap | output | 8 | Access-permission field |

## Verification
Two events can fall in the same cycle: the end of a walk (the done pulse) and a requester that keeps `req_valid` high all the way through it. The bench holds the request high for a full walk. It then checks that exactly the expected number of reads occurred and that the request is taken only after `done`. A second instance built without tiny support shares the stimulus. On a fine-table pointer, that instance must fault after one read in the same cycle in which the main instance issues its second read.

// File: rtl/tt_walker.sv
module tt_walker #(
  parameter bit TINY_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] table_base,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [31:0] pa,
  output logic [1:0]  page_type,
  output logic [1:0]  cb,
  output logic [3:0]  domain,
  output logic [7:0]  ap
);
  typedef enum logic [2:0] {S_IDLE, S_L1REQ, S_L1WAIT, S_L2REQ, S_L2WAIT, S_DONE} st_t;

  st_t         state;
  logic [31:0] va_q, addr_q, pa_q;
  logic [1:0]  ptype_q, cb_q;
  logic [3:0]  dom_q;
  logic [7:0]  ap_q;
  logic        fault_q;

  wire [31:0] d       = mem_rdata;
  wire        l1_miss = (d[1:0] == 2'd0) || (!TINY_EN && d[1:0] == 2'd3);

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign mem_req   = (state == S_L1REQ) || (state == S_L2REQ);
  assign mem_addr  = addr_q;
  assign done      = (state == S_DONE);
  assign fault     = fault_q;
  assign pa        = pa_q;
  assign page_type = ptype_q;
  assign cb        = cb_q;
  assign domain    = dom_q;
  assign ap        = ap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      ptype_q <= '0;
      cb_q    <= '0;
      dom_q   <= '0;
      ap_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          addr_q <= {table_base[31:14], req_va[31:20], 2'b00};
          state  <= S_L1REQ;
        end
        S_L1REQ: state <= S_L1WAIT;
        S_L1WAIT: if (mem_rvalid) begin
          if (l1_miss) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            ptype_q <= '0;
            cb_q    <= '0;
            dom_q   <= '0;
            ap_q    <= '0;
            state   <= S_DONE;
          end else begin
            dom_q <= d[8:5];
            case (d[1:0])
              2'd2: begin
                pa_q    <= {d[31:20], va_q[19:0]};
                ptype_q <= 2'd0;
                cb_q    <= d[3:2];
                ap_q    <= {6'b0, d[11:10]};
                state   <= S_DONE;
              end
              2'd1: begin
                addr_q <= {d[31:10], va_q[19:12], 2'b00};
                state  <= S_L2REQ;
              end
              default: begin
                addr_q <= {d[31:12], va_q[19:10], 2'b00};
                state  <= S_L2REQ;
              end
            endcase
          end
        end
        S_L2REQ: state <= S_L2WAIT;
        S_L2WAIT: if (mem_rvalid) begin
          state <= S_DONE;
          if (d[1:0] == 2'd0) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            ptype_q <= '0;
            cb_q    <= '0;
            dom_q   <= '0;
            ap_q    <= '0;
          end else begin
            ptype_q <= d[1:0];
            cb_q    <= d[3:2];
            case (d[1:0])
              2'd1: begin
                pa_q <= {d[31:16], va_q[15:0]};
                ap_q <= d[11:4];
              end
              2'd2: begin
                pa_q <= {d[31:12], va_q[11:0]};
                ap_q <= d[11:4];
              end
              default: begin
                pa_q <= {d[31:10], va_q[9:0]};
                ap_q <= {6'b0, d[5:4]};
              end
            endcase
          end
        end
        S_DONE: begin
          fault_q <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req && busy) else $error("accept"); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req) else $error("req pulse"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy) else $error("done pulse"); // R11
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done) else $error("fault w/o done"); // R11
  AST_NO_READ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req) else $error("read at done"); // R9
  AST_SECTION_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && page_type == 2'd0 |-> pa[19:0] == va_q[19:0]) else $error("section pa"); // R3
  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && page_type == 2'd2 |-> pa[11:0] == va_q[11:0]) else $error("small pa"); // R7
  AST_TINY_OFF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !TINY_EN && state == S_L1WAIT && mem_rvalid && mem_rdata[1:0] == 2'd3 |=> fault && done) else $error("tiny off"); // R10
endmodule

// File: tb/sim_tt_walker.sv
module sim_tt_walker;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [31:0] table_base = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic        req_ready, mem_req, busy, done, fault;
  logic [31:0] mem_addr, pa;
  logic [1:0]  page_type, cb;
  logic [3:0]  domain;
  logic [7:0]  ap;

  logic        r1_ready, r1_mreq, r1_busy, r1_done, r1_fault;
  logic [31:0] r1_maddr, r1_pa;
  logic [1:0]  r1_pt, r1_cb;
  logic [3:0]  r1_dom;
  logic [7:0]  r1_ap;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  tt_walker #(.TINY_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .table_base(table_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fault(fault), .pa(pa), .page_type(page_type), .cb(cb), .domain(domain), .ap(ap));

  tt_walker #(.TINY_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r1_ready),
    .req_va(req_va), .table_base(table_base), .mem_req(r1_mreq), .mem_addr(r1_maddr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(r1_busy), .done(r1_done),
    .fault(r1_fault), .pa(r1_pa), .page_type(r1_pt), .cb(r1_cb), .domain(r1_dom), .ap(r1_ap));

  logic [31:0] mem [logic [31:0]];
  logic [31:0] addrq[$];
  int  latency = 1;
  bit  pend = 0;
  int  cnt = 0;
  logic [31:0] paddr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (pend && cnt == 0) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= rd(paddr);
      pend = 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend) cnt--;
    end
    if (mem_req) begin
      pend = 1;
      cnt = latency - 1;
      paddr = mem_addr;
      addrq.push_back(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic ref_walk(input logic [31:0] va, input logic [31:0] tb,
    output bit f, output logic [31:0] epa, output logic [1:0] ept, output logic [1:0] ecb,
    output logic [3:0] edom, output logic [7:0] eap, output int nrd,
    output logic [31:0] a1, output logic [31:0] a2, output bit l1_fine);
    logic [31:0] d1, d2;
    f = 0; epa = 0; ept = 0; ecb = 0; edom = 0; eap = 0; a2 = 0; l1_fine = 0;
    a1 = (tb & 32'hFFFF_C000) | ((va >> 20) << 2);
    d1 = rd(a1);
    nrd = 1;
    if (d1[1:0] == 0) begin f = 1; return; end
    edom = d1[8:5];
    if (d1[1:0] == 2) begin
      epa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      ecb = d1[3:2]; eap = {6'b0, d1[11:10]}; ept = 0;
      return;
    end
    nrd = 2;
    if (d1[1:0] == 1) a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
    else begin
      a2 = (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2);
      l1_fine = 1;
    end
    d2 = rd(a2);
    if (d2[1:0] == 0) begin f = 1; edom = 0; return; end
    ecb = d2[3:2]; ept = d2[1:0];
    if (d2[1:0] == 1) begin epa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF); eap = d2[11:4]; end
    else if (d2[1:0] == 2) begin epa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF); eap = d2[11:4]; end
    else begin epa = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF); eap = {6'b0, d2[5:4]}; end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [31:0] tb, input int lat,
                          input bit hold, input string tag);
    bit f, fine, u1f;
    logic [31:0] epa, a1, a2;
    logic [1:0] ept, ecb;
    logic [3:0] edom;
    logic [7:0] eap;
    int nrd, n, u1n, expn;
    ref_walk(va, tb, f, epa, ept, ecb, edom, eap, nrd, a1, a2, fine);
    @(negedge clk);
    latency = lat;
    addrq.delete();
    req_va = va; table_base = tb; req_valid = 1'b1;
    n = 0; u1n = 0; u1f = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (!hold && n == 1) req_valid = 1'b0;
      if (r1_done && u1n == 0) begin u1n = n; u1f = r1_fault; end
      if (done) break;
      chk(busy && !req_ready, "R11", {tag, " busy/ready during walk"}, {busy, req_ready}, 2'b10);
      if (n > 60) break;
    end
    if (hold) req_valid = 1'b0;
    expn = (nrd == 1) ? 2 + lat : 3 + 2 * lat;
    chk(n == expn, "R11", {tag, " done cycle"}, n, expn);
    chk(fault == f, f ? "R9" : "R11", {tag, " fault"}, fault, f);
    chk(pa == epa, tag, "pa", pa, epa);
    chk(page_type == ept, tag, "page type", page_type, ept);
    chk(cb == ecb, tag, "cb", cb, ecb);
    chk(domain == edom, tag, "domain", domain, edom);
    chk(ap == eap, tag, "ap", ap, eap);
    chk(addrq.size() == nrd, hold ? "R11" : "R9", {tag, " read count"}, addrq.size(), nrd);
    if (addrq.size() >= 1) chk(addrq[0] == a1, "R2", {tag, " first address"}, addrq[0], a1);
    if (nrd == 2 && addrq.size() == 2)
      chk(addrq[1] == a2, fine ? "R5" : "R4", {tag, " second address"}, addrq[1], a2);
    if (fine) begin
      chk(u1n == 2 + lat && u1f, "R10", {tag, " tiny-off fault cycle"}, u1n, 2 + lat);
    end
    @(negedge clk);
    chk(!done && !fault && !busy && req_ready, "R11", {tag, " after done"},
        {done, fault, busy, req_ready}, 4'b0001);
  endtask

  localparam logic [31:0] TB = 32'h0001_C3FF;

  function automatic logic [31:0] l1a(input logic [31:0] va);
    return (TB & 32'hFFFF_C000) | ((va >> 20) << 2);
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mem[l1a(32'h1234_5678)] = 32'hABC0_0000 | (3 << 10) | (5 << 5) | (2 << 2) | 2;
    mem[l1a(32'h2005_A123)] = 32'h0008_0400 | (9 << 5) | 1;
    mem[32'h0008_0400 | (32'h5A << 2)] = 32'h7654_0000 | (32'hA5 << 4) | (1 << 2) | 1;
    mem[32'h0008_0400 | (32'h7B << 2)] = 32'h1234_5000 | (32'h3C << 4) | (3 << 2) | 2;
    mem[l1a(32'h3009_C7AB)] = 32'h000A_3000 | (15 << 5) | 3;
    mem[32'h000A_3000 | (32'h271 << 2)] = 32'h8765_4C00 | 32'hC0 | (2 << 4) | (1 << 2) | 3;
    mem[32'h000A_3000 | (32'h3FF << 2)] = 32'hCAFE_0000 | (32'h5A << 4) | (2 << 2) | 1;
    mem[l1a(32'h7FF0_0ABC)] = 32'h0550_0000 | (1 << 10) | (2 << 5) | (1 << 2) | 2;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req && req_ready, "R1", "reset outputs",
        {busy, done, fault, mem_req, req_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req && req_ready, "R1", "after reset release",
        {busy, done, fault, mem_req, req_ready}, 5'b00001);

    run_walk(32'h1234_5678, TB, 1, 0, "R3");
    run_walk(32'h2005_A123, TB, 2, 0, "R6");
    run_walk(32'h2007_BFFF, TB, 3, 0, "R7");
    run_walk(32'h3009_C7AB, TB, 1, 0, "R8");
    run_walk(32'h4000_0000, TB, 2, 0, "R9");
    run_walk(32'h2001_0000, TB, 4, 0, "R9");
    run_walk(32'h300F_FC00, TB, 2, 0, "R5");
    run_walk(32'h7FF0_0ABC, TB, 3, 1, "R11");
    run_walk(32'h3009_C7AB, TB, 4, 1, "R10");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule